// File: doc/BRIEF.md
# Serial Register Port with Shared Lock-Detect Pin

This block is a four-wire serial slave (serial clock, active-low chip select, data in, data out) that lets a host controller read and write a small register file. Each addressed location is one of four kinds: read-only, write-only, read/write, or strobe. A strobe location stores nothing. Writing it fires a single-cycle pulse on a dedicated output.

The data-out pin is shared with a lock-detect status level, which the block receives as an input. Two 2-bit mode fields select what the pin does outside a read. One field sits in the control register at address 0x02, bits [1:0]. The other sits in the control register at address 0x1A, bits [13:12]. In the default behaviour the pin is released (output enable low) whenever no read data is being returned. In the lock-detect behaviour the pin carries the lock level whenever no read data is being returned.

All serial inputs are resynchronised into the system clock domain and edge-detected there. The serial clock may therefore run at up to one quarter of the system clock. A 200 MHz system clock accepts a 50 MHz serial clock. The pin is presented as a data/enable pair for a pad cell outside the block.

Top module: `serial_regport`

## Requirements
- R1: A frame is 31 bits, most significant first, each sampled on a rising serial clock edge while chip select is low. The first bit is the direction (1 = read, 0 = write), then 6 address bits, then 24 data bits. A write to a read/write register (0x02 drives `ctrl_a`, 0x1A drives `ctrl_b`) updates it after chip select rises, and a later read returns the written value.
- R2: Read-only locations return fixed data: 0x00 returns the parameter `ID_VALUE` and 0x07 returns the `status_in` input. Writes to them change nothing that a later read returns.
- R3: The write-only location 0x06 drives `wo_data` after a write. It holds its value until the next write to it, and reading it returns zero.
- R4: A write to strobe location 0x04 or 0x05 gives exactly one system-clock-wide pulse on `strobe[0]` or `strobe[1]` respectively, after chip select rises. It gives no pulse on the other strobe bit. Reading a strobe location returns zero.
- R5: Unless `ctrl_a[1:0]` == 2'b11 and `ctrl_b[13:12]` == 2'b01, `pad_oe` is low whenever no read data phase is in progress. This includes every combination outside that one, and the reset state.
- R6: With `ctrl_a[1:0]` == 2'b11 and `ctrl_b[13:12]` == 2'b01, `pad_oe` is high and `pad_out` follows `lock_det` whenever no read data phase is in progress.
- R7: During the data phase of a read the pin is driven (`pad_oe` high) in either mode. The phase runs from after the 7th rising edge until chip select rises. The 24 data bits appear most significant first, each updated after a falling serial clock edge, so the host samples them on rising edges 8 to 31.
- R8: A write frame never drives read data onto the pin. In the default mode `pad_oe` stays low throughout it. In the lock-detect mode `pad_out` keeps following `lock_det`.
- R9: Chip select rising before all 31 bits have arrived discards the frame with no register update. The pin returns to its idle behaviour, and the next complete frame works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csn | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| lock_det | input | 1 | Lock-detect status level to share on the pin |
| status_in | input | 24 | Value returned by read-only location 0x07 |
| pad_out | output | 1 | Data driven onto the shared pin |
| pad_oe | output | 1 | Output enable of the shared pin (0 = high impedance) |
| ctrl_a | output | 24 | Read/write register at 0x02 |
| ctrl_b | output | 24 | Read/write register at 0x1A |
| wo_data | output | 24 | Write-only register at 0x06 |
| strobe | output | 2 | One-cycle pulses from strobe locations 0x04 and 0x05 |

## Verification
The bench builds the block with the default 6-bit address and 24-bit data widths and two strobe locations. It sets a non-trivial `ID_VALUE` (0xA5C31E), so that a stuck-at-zero read path cannot pass the read-only check. With two strobe locations, a pulse on the wrong bit or a doubled pulse shows up as a counter mismatch. The 24-bit width keeps bits [13:12] of the second control register inside the data field, so every mode-field combination can be reached from serial writes. The serial clock runs at one twelfth of the system clock, which leaves room for the resynchroniser delay between each falling edge and the host's sampling edge.

// File: rtl/sregport_pkg.sv
package sregport_pkg;

    // Access kind of one addressed location
    typedef enum logic [2:0] {
        RK_NONE,
        RK_RO,
        RK_WO,
        RK_RW,
        RK_STB
    } reg_kind_e;

endpackage

// File: rtl/sregport_sync.sv
module sregport_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d    = stage_q;
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sregport_frame.sv
module sregport_frame #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_active_o,
    output logic              sdo_o
);

    localparam int HDR_LEN   = 1 + ADDR_W;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        logic                 sclk_prev;
        logic                 csn_prev;
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_LEN-1:0] shin;
        logic [ADDR_W-1:0]    addr;
        logic                 load_pend;
        logic                 rd_active;
        logic [DATA_W-1:0]    shout;
        logic                 sdo;
        logic                 wr_en;
        logic [ADDR_W-1:0]    wr_addr;
        logic [DATA_W-1:0]    wr_data;
    } frame_st_t;

    frame_st_t d, q;
    logic      rise, fall;

    assign rise = sclk_s & ~q.sclk_prev;
    assign fall = ~sclk_s & q.sclk_prev;

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_s;
        d.csn_prev  = csn_s;
        d.wr_en     = 1'b0;
        if (csn_s) begin
            // Frame end: commit only a complete write frame
            if (!q.csn_prev && q.cnt == CNT_W'(FRAME_LEN) && !q.shin[FRAME_LEN-1]) begin
                d.wr_en   = 1'b1;
                d.wr_addr = q.shin[DATA_W +: ADDR_W];
                d.wr_data = q.shin[DATA_W-1:0];
            end
            d.cnt       = '0;
            d.load_pend = 1'b0;
            d.rd_active = 1'b0;
            d.sdo       = 1'b0;
        end else begin
            // Extra clocks past a full frame are ignored
            if (rise && q.cnt != CNT_W'(FRAME_LEN)) begin
                d.shin = {q.shin[FRAME_LEN-2:0], sdi_s};
                d.cnt  = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(HDR_LEN - 1) && d.shin[ADDR_W]) begin
                    d.addr      = d.shin[ADDR_W-1:0];
                    d.load_pend = 1'b1;
                end
            end
            if (q.load_pend) begin
                d.load_pend = 1'b0;
                d.rd_active = 1'b1;
                d.shout     = rdata_i;
                d.sdo       = 1'b0;
            end else if (fall && q.rd_active) begin
                d.sdo   = q.shout[DATA_W-1];
                d.shout = {q.shout[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.csn_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o   = q.addr;
    assign wr_en_o     = q.wr_en;
    assign wr_addr_o   = q.wr_addr;
    assign wr_data_o   = q.wr_data;
    assign rd_active_o = q.rd_active;
    assign sdo_o       = q.sdo;

    // Read data phase begins right after the header is complete
    assert_read_load_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rd_active) |-> (q.cnt == CNT_W'(HDR_LEN)));

    // Read data bits change only after a falling serial clock edge
    assert_sdo_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rd_active && $past(q.rd_active) && !$stable(q.sdo)) |-> $past(fall));

endmodule

// File: rtl/sregport_regs.sv
module sregport_regs import sregport_pkg::*; #(
    parameter int                ADDR_W     = 6,
    parameter int                DATA_W     = 24,
    parameter logic [DATA_W-1:0] ID_VALUE   = 24'h5A0001,
    parameter logic [ADDR_W-1:0] ADDR_ID    = 6'h00,
    parameter logic [ADDR_W-1:0] ADDR_CFG_A = 6'h02,
    parameter logic [ADDR_W-1:0] ADDR_STAT  = 6'h07,
    parameter logic [ADDR_W-1:0] ADDR_WO    = 6'h06,
    parameter logic [ADDR_W-1:0] ADDR_CFG_B = 6'h1A,
    parameter int                STB_BASE   = 4,
    parameter int                NUM_STB    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic [DATA_W-1:0]  stat_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [DATA_W-1:0]  cfg_a_o,
    output logic [DATA_W-1:0]  cfg_b_o,
    output logic [DATA_W-1:0]  wo_o,
    output logic [NUM_STB-1:0] strobe_o
);

    typedef struct packed {
        logic [DATA_W-1:0]  cfg_a;
        logic [DATA_W-1:0]  cfg_b;
        logic [DATA_W-1:0]  wo;
        logic [NUM_STB-1:0] stb;
    } regs_st_t;

    regs_st_t           d, q;
    logic [NUM_STB-1:0] stb_hit;

    function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] a);
        reg_kind_e k;
        k = RK_NONE;
        if (a == ADDR_ID || a == ADDR_STAT)
            k = RK_RO;
        else if (a == ADDR_CFG_A || a == ADDR_CFG_B)
            k = RK_RW;
        else if (a == ADDR_WO)
            k = RK_WO;
        else if (int'(a) >= STB_BASE && int'(a) < STB_BASE + NUM_STB)
            k = RK_STB;
        return k;
    endfunction

    for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
        assign stb_hit[g] = (int'(wr_addr_i) == STB_BASE + g);

        // A strobe never lasts more than one system clock
        assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
            q.stb[g] |=> !q.stb[g]);
    end

    always_comb begin
        d     = q;
        d.stb = '0;
        if (wr_en_i) begin
            case (kind_of(wr_addr_i))
                RK_RW: begin
                    if (wr_addr_i == ADDR_CFG_A) d.cfg_a = wr_data_i;
                    else                         d.cfg_b = wr_data_i;
                end
                RK_WO:   d.wo  = wr_data_i;
                RK_STB:  d.stb = stb_hit;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (kind_of(rd_addr_i))
            RK_RO:   rdata_o = (rd_addr_i == ADDR_ID) ? ID_VALUE : stat_i;
            RK_RW:   rdata_o = (rd_addr_i == ADDR_CFG_A) ? q.cfg_a : q.cfg_b;
            default: rdata_o = '0;
        endcase
    end

    assign cfg_a_o  = q.cfg_a;
    assign cfg_b_o  = q.cfg_b;
    assign wo_o     = q.wo;
    assign strobe_o = q.stb;

    // Write-only storage moves only on a committed write
    assert_wo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(q.wo));

endmodule

// File: rtl/sregport_pinmux.sv
module sregport_pinmux (
    input  logic       rd_active_i,
    input  logic       sdo_i,
    input  logic       lock_i,
    input  logic [1:0] mode_a_i,
    input  logic [1:0] mode_b_i,
    output logic       pad_out_o,
    output logic       pad_oe_o
);

    logic lock_sel;

    // Only one exact combination shares the pin with lock detect
    assign lock_sel = (mode_a_i == 2'b11) && (mode_b_i == 2'b01);

    always_comb begin
        if (rd_active_i) begin
            pad_out_o = sdo_i;
            pad_oe_o  = 1'b1;
        end else if (lock_sel) begin
            pad_out_o = lock_i;
            pad_oe_o  = 1'b1;
        end else begin
            pad_out_o = 1'b0;
            pad_oe_o  = 1'b0;
        end
    end

endmodule

// File: rtl/serial_regport.sv
module serial_regport #(
    parameter int          ADDR_W   = 6,
    parameter int          DATA_W   = 24,
    parameter logic [23:0] ID_VALUE = 24'h5A0001,
    parameter int          NUM_STB  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               csn,
    input  logic               sdi,
    input  logic               lock_det,
    input  logic [DATA_W-1:0]  status_in,
    output logic               pad_out,
    output logic               pad_oe,
    output logic [DATA_W-1:0]  ctrl_a,
    output logic [DATA_W-1:0]  ctrl_b,
    output logic [DATA_W-1:0]  wo_data,
    output logic [NUM_STB-1:0] strobe
);

    localparam int MODE_A_LSB = 0;
    localparam int MODE_B_LSB = 12;

    logic [2:0]        sync_s;
    logic              sclk_s, csn_s, sdi_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rdata, wr_data;
    logic              wr_en, rd_active, sdo;

    sregport_sync #(
        .WIDTH   (3),
        .STAGES  (2),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi, csn, sclk}),
        .sync_o  (sync_s)
    );

    assign sclk_s = sync_s[0];
    assign csn_s  = sync_s[1];
    assign sdi_s  = sync_s[2];

    sregport_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .csn_s       (csn_s),
        .sdi_s       (sdi_s),
        .rdata_i     (rdata),
        .rd_addr_o   (rd_addr),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .rd_active_o (rd_active),
        .sdo_o       (sdo)
    );

    sregport_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ID_VALUE (DATA_W'(ID_VALUE)),
        .NUM_STB  (NUM_STB)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .stat_i    (status_in),
        .rdata_o   (rdata),
        .cfg_a_o   (ctrl_a),
        .cfg_b_o   (ctrl_b),
        .wo_o      (wo_data),
        .strobe_o  (strobe)
    );

    sregport_pinmux u_pinmux (
        .rd_active_i (rd_active),
        .sdo_i       (sdo),
        .lock_i      (lock_det),
        .mode_a_i    (ctrl_a[MODE_A_LSB +: 2]),
        .mode_b_i    (ctrl_b[MODE_B_LSB +: 2]),
        .pad_out_o   (pad_out),
        .pad_oe_o    (pad_oe)
    );

    logic lock_mode_chk;
    assign lock_mode_chk = (ctrl_a[MODE_A_LSB +: 2] == 2'b11) &&
                           (ctrl_b[MODE_B_LSB +: 2] == 2'b01);

    assert_idle_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_active && !lock_mode_chk) |-> !pad_oe);

    assert_lock_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_active && lock_mode_chk) |-> (pad_oe && pad_out == lock_det));

    assert_read_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> (pad_oe && pad_out == sdo));

    assert_write_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_active);

endmodule

// File: tb/serial_regport_test.sv
module serial_regport_test;

    localparam int          AW     = 6;
    localparam int          DW     = 24;
    localparam int          FLEN   = 1 + AW + DW;
    localparam logic [23:0] ID_VAL = 24'hA5C31E;
    localparam int          HALF   = 6;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          sclk = 1'b0, csn = 1'b1, sdi = 1'b0, lock_det = 1'b0;
    logic [DW-1:0] status_in = 24'h3C5A96;
    logic          pad_out, pad_oe;
    logic [DW-1:0] ctrl_a, ctrl_b, wo_data;
    logic [1:0]    strobe;

    serial_regport #(.ID_VALUE(ID_VAL)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
        .lock_det(lock_det), .status_in(status_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
        .wo_data(wo_data), .strobe(strobe)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string         req;
        logic [DW-1:0] val;
    } exp_t;
    exp_t exp_q[$];

    int   stb_cnt0 = 0, stb_cnt1 = 0;
    logic oe_seen = 1'b0, hi_seen = 1'b0;

    always @(negedge clk) begin
        if (strobe[0]) stb_cnt0++;
        if (strobe[1]) stb_cnt1++;
        if (pad_oe)    oe_seen = 1'b1;
        if (pad_out)   hi_seen = 1'b1;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic send_frame(input logic rw, input logic [AW-1:0] a,
                              input logic [DW-1:0] data, input int nbits);
        logic [FLEN-1:0] w;
        w = {rw, a, data};
        @(negedge clk);
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[FLEN-1-i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        sdi = 1'b0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] data);
        send_frame(1'b0, a, data, FLEN);
    endtask

    task automatic rd_expect(input string req, input logic [AW-1:0] a,
                             input logic [DW-1:0] exp);
        exp_t e;
        e.req = req;
        e.val = exp;
        exp_q.push_back(e);
        send_frame(1'b1, a, '0, FLEN);
    endtask

    // Monitor: rebuilds each frame from the pins and scores read frames
    initial begin : monitor
        logic [FLEN-1:0] sin;
        logic [FLEN-1:0] sout;
        int              n;
        logic            oe_ok;
        exp_t            e;
        forever begin
            @(negedge csn);
            n     = 0;
            oe_ok = 1'b1;
            sin   = '0;
            sout  = '0;
            forever begin
                @(posedge sclk or posedge csn);
                if (csn) break;
                if (n < FLEN) begin
                    sin[FLEN-1-n]  = sdi;
                    sout[FLEN-1-n] = pad_out;
                    if (n >= 1 + AW && !pad_oe) oe_ok = 1'b0;
                end
                n++;
            end
            if (n == FLEN && sin[FLEN-1]) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R1 unexpected read: got %h expected none", sout[DW-1:0]);
                end else begin
                    e = exp_q.pop_front();
                    check(e.req, "read data", 32'(sout[DW-1:0]), 32'(e.val));
                    check("R7", "pin enabled during read data", 32'(oe_ok), 32'd1);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Reset state
        check("R5", "reset pad_oe", 32'(pad_oe), 32'd0);
        check("R1", "reset ctrl_a", 32'(ctrl_a), 32'd0);
        check("R3", "reset wo_data", 32'(wo_data), 32'd0);
        check("R4", "reset strobe", 32'(strobe), 32'd0);

        // R1 read/write registers
        wr(6'h02, 24'h123456);
        check("R1", "ctrl_a after write", 32'(ctrl_a), 32'h123456);
        rd_expect("R1", 6'h02, 24'h123456);
        wr(6'h1A, 24'hABCDEF);
        check("R1", "ctrl_b after write", 32'(ctrl_b), 32'hABCDEF);
        rd_expect("R1", 6'h1A, 24'hABCDEF);

        // R2 read-only locations
        rd_expect("R2", 6'h00, ID_VAL);
        wr(6'h00, 24'h111111);
        rd_expect("R2", 6'h00, ID_VAL);
        rd_expect("R2", 6'h07, 24'h3C5A96);
        wr(6'h07, 24'h222222);
        status_in = 24'h0F1E2D;
        rd_expect("R2", 6'h07, 24'h0F1E2D);

        // R3 write-only
        wr(6'h06, 24'h0F0F0F);
        check("R3", "wo_data after write", 32'(wo_data), 32'h0F0F0F);
        rd_expect("R3", 6'h06, 24'h000000);
        check("R3", "wo_data held across read", 32'(wo_data), 32'h0F0F0F);

        // R4 strobes
        stb_cnt0 = 0; stb_cnt1 = 0;
        wr(6'h04, 24'hFFFFFF);
        check("R4", "strobe0 pulses after 0x04", 32'(stb_cnt0), 32'd1);
        check("R4", "strobe1 pulses after 0x04", 32'(stb_cnt1), 32'd0);
        stb_cnt0 = 0; stb_cnt1 = 0;
        wr(6'h05, 24'h000001);
        check("R4", "strobe0 pulses after 0x05", 32'(stb_cnt0), 32'd0);
        check("R4", "strobe1 pulses after 0x05", 32'(stb_cnt1), 32'd1);
        rd_expect("R4", 6'h04, 24'h000000);

        // R5 combinations that keep the pin released
        lock_det = 1'b1;
        wr(6'h02, 24'h000003);
        wr(6'h1A, 24'h000000);
        check("R5", "oe with mode_b 00", 32'(pad_oe), 32'd0);
        wr(6'h1A, 24'h003000);
        check("R5", "oe with mode_b 11", 32'(pad_oe), 32'd0);
        wr(6'h02, 24'h000002);
        wr(6'h1A, 24'h001000);
        check("R5", "oe with mode_a 10", 32'(pad_oe), 32'd0);

        // R8 write frame in released mode
        oe_seen = 1'b0;
        wr(6'h06, 24'h777777);
        check("R8", "oe during write frame", 32'(oe_seen), 32'd0);

        // R6 lock-detect sharing
        wr(6'h02, 24'h000003);
        check("R6", "oe in lock mode", 32'(pad_oe), 32'd1);
        check("R6", "pad follows lock high", 32'(pad_out), 32'd1);
        lock_det = 1'b0;
        repeat (2) @(negedge clk);
        check("R6", "pad follows lock low", 32'(pad_out), 32'd0);

        // R7 reads in lock mode
        rd_expect("R7", 6'h02, 24'h000003);
        rd_expect("R7", 6'h1A, 24'h001000);

        // R8 write frame in lock mode with lock low
        hi_seen = 1'b0;
        wr(6'h06, 24'hFFFFFF);
        check("R8", "pad high during write in lock mode", 32'(hi_seen), 32'd0);

        // R9 aborted frames
        wr(6'h1A, 24'h000000);
        send_frame(1'b0, 6'h02, 24'h555555, 20);
        check("R9", "ctrl_a after aborted write", 32'(ctrl_a), 32'h000003);
        send_frame(1'b0, 6'h06, 24'h123123, FLEN - 1);
        check("R9", "wo_data after 30-bit write", 32'(wo_data), 32'hFFFFFF);
        oe_seen = 1'b0;
        send_frame(1'b1, 6'h00, '0, 15);
        check("R7", "pin driven in partial read", 32'(oe_seen), 32'd1);
        check("R9", "oe after aborted read", 32'(pad_oe), 32'd0);
        rd_expect("R9", 6'h02, 24'h000003);

        repeat (10) @(negedge clk);
        check("R1", "reads left unanswered", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule